// File: doc/BRIEF.md
# Short Vector Issue Sequencer

This block turns one short-vector floating-point arithmetic instruction into a run of per-element operations. A decoded instruction, with destination and two source register indices, an opcode, an encoded length field and an encoded stride field, is accepted in one issue slot. The block then sends one element per cycle into the first execute stage (E1) of a seven-stage multiply-accumulate pipeline. For each element it produces the destination and source register indices.

The element tags move through E1 to E7 and then a writeback stage. The block reports which stages are occupied, so a scheduler can see structural use of the pipeline. No arithmetic is performed; the stages carry tags only.

A stall input from downstream freezes the element that sits in E1. The stages after E1 keep moving, and a bubble enters E2. A new instruction is taken as soon as E1 is free, even while earlier elements are still in flight, so the sequencer can run alongside other outstanding work such as a load-multiple.

Top module: `vec_issue_seq`

## Requirements
- R1: While rst_ni is low, and on the first cycle after reset, busy_o, issue_valid_o, iter_done_o, wb_valid_o and every bit of stage_occ_o are 0.
- R2: If start_i is high while busy_o is low, then in the next cycle busy_o is 1 and E1 holds element 0. For element 0, issue_idx_o is 0 and the issue indices equal dst_i, src_a_i and src_b_i as sampled at acceptance.
- R3: The instruction issues len_i+1 elements, numbered 0 upward on issue_idx_o. With no stall they issue on consecutive cycles; for example len_i=3'b011 gives four E1 cycles in a row.
- R4: The register step between successive elements is stride_i+1. So 2'b00 steps by one and 2'b11 steps by four.
- R5: The low three bits of each index form the offset within an 8-register bank, and this offset wraps modulo 8. The bank bits [4:3] keep the value of the base index.
- R6: len_i=3'b000 acts as a scalar. The block gives one E1 cycle, one issued element, and busy_o high for one cycle only.
- R7: While stall_i is high and busy_o is high, issue_valid_o is 0 and the element in E1 stays the same. The sequence then resumes with that element, without skipping or repeating any element.
- R8: iter_done_o is 1 in exactly the cycle in which the last element leaves E1, and busy_o is 0 in the cycle after. start_i while busy_o is high is ignored, and the running sequence continues unchanged.
- R9: An element issued in cycle t shows in stage_occ_o bit k (bit 0 is E1, bits 1..6 are E2..E7, bit 7 is writeback) in cycle t+k. In cycle t+7, wb_valid_o is 1 with that element's wb_dst_o and wb_idx_o.
- R10: A new instruction is accepted in the first cycle in which busy_o is low, whatever is still occupying E2 to writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | A new vector instruction is presented |
| op_i | input | 4 | Opcode of the instruction |
| dst_i | input | 5 | Base destination register index |
| src_a_i | input | 5 | Base first source register index |
| src_b_i | input | 5 | Base second source register index |
| len_i | input | 3 | Length field; the element count is len_i+1 |
| stride_i | input | 2 | Stride field; the step is stride_i+1 |
| stall_i | input | 1 | Downstream stall; holds the element in E1 |
| issue_valid_o | output | 1 | An element leaves E1 this cycle |
| issue_idx_o | output | 3 | Number of the element in E1 |
| issue_op_o | output | 4 | Opcode of the running instruction |
| issue_dst_o | output | 5 | Destination index of the element in E1 |
| issue_src_a_o | output | 5 | First source index of the element in E1 |
| issue_src_b_o | output | 5 | Second source index of the element in E1 |
| busy_o | output | 1 | E1 is occupied by the running instruction |
| iter_done_o | output | 1 | The last element leaves E1 this cycle |
| stage_occ_o | output | 8 | Occupancy of E1..E7 (bits 0..6) and writeback (bit 7) |
| wb_valid_o | output | 1 | An element is in writeback |
| wb_dst_o | output | 5 | Destination index of the element in writeback |
| wb_idx_o | output | 3 | Element number of the element in writeback |

## Verification
An accepted instruction becomes visible one clock edge later: busy_o and the element-0 indices appear in the cycle after start_i. issue_valid_o and iter_done_o are combinational in stall_i within that cycle. Stage bit k follows an issue by k edges, and writeback follows it by seven. The reference model in the bench moves its own stage queue forward at each edge. The bench drives inputs just after the falling edge and compares every output one time unit later, so each expected value lines up with the edge count above. Separate checks count the issued elements per instruction, and a start presented while busy is shown to leave the indices of the running sequence unchanged.

// File: rtl/vis_pkg.sv
package vis_pkg;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned OFF_W  = 3;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned LEN_W  = 3;
  localparam int unsigned STR_W  = 2;
  localparam int unsigned EX_NUM = 7;

  typedef struct packed {
    logic             v;
    logic [REG_W-1:0] dst;
    logic [LEN_W-1:0] idx;
  } tag_t;
endpackage

// File: rtl/vis_ctrl.sv
module vis_ctrl #(
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             stall_i,
  output logic             accept_o,
  output logic             e1_v_o,
  output logic             adv_o,
  output logic             last_o,
  output logic [LEN_W-1:0] cnt_o
);
  logic             e1_v_q;
  logic [LEN_W-1:0] cnt_q, len_q;

  assign accept_o = start_i & ~e1_v_q;
  assign adv_o    = e1_v_q & ~stall_i;
  assign last_o   = (cnt_q == len_q);
  assign e1_v_o   = e1_v_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e1_v_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
    end else if (accept_o) begin
      e1_v_q <= 1'b1;
      cnt_q  <= '0;
      len_q  <= len_i;
    end else if (adv_o) begin
      if (last_o) e1_v_q <= 1'b0;
      else        cnt_q  <= cnt_q + LEN_W'(1);
    end
  end
endmodule

// File: rtl/vis_idx_gen.sv
module vis_idx_gen #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned OFF_W = 3,
  parameter int unsigned LEN_W = 3,
  parameter int unsigned STR_W = 2
) (
  input  logic [REG_W-1:0] base_i,
  input  logic [STR_W-1:0] stride_i,
  input  logic [LEN_W-1:0] cnt_i,
  output logic [REG_W-1:0] idx_o
);
  logic [OFF_W-1:0] step, ofs;

  always_comb begin
    step = OFF_W'(stride_i) + OFF_W'(1);
    // offset wraps inside the bank, bank bits pass through
    ofs  = base_i[OFF_W-1:0] + OFF_W'(cnt_i) * step;
    idx_o = {base_i[REG_W-1:OFF_W], ofs};
  end
endmodule

// File: rtl/vis_tag_pipe.sv
module vis_tag_pipe
  import vis_pkg::*;
#(
  parameter int unsigned DEPTH = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tag_t             tag_i,
  output logic [DEPTH-1:0] occ_o,
  output tag_t             tail_o
);
  tag_t stg_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stg
    tag_t nxt;
    if (k == 0) begin : g_head
      assign nxt = tag_i;
    end else begin : g_body
      assign nxt = stg_q[k-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[k] <= '0;
      else         stg_q[k] <= nxt;
    end
    assign occ_o[k] = stg_q[k].v;
  end

  assign tail_o = stg_q[DEPTH-1];
endmodule

// File: rtl/vec_issue_seq.sv
module vec_issue_seq
  import vis_pkg::*;
#(
  parameter int unsigned N_EX = EX_NUM
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [OP_W-1:0]    op_i,
  input  logic [REG_W-1:0]   dst_i,
  input  logic [REG_W-1:0]   src_a_i,
  input  logic [REG_W-1:0]   src_b_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [STR_W-1:0]   stride_i,
  input  logic               stall_i,
  output logic               issue_valid_o,
  output logic [LEN_W-1:0]   issue_idx_o,
  output logic [OP_W-1:0]    issue_op_o,
  output logic [REG_W-1:0]   issue_dst_o,
  output logic [REG_W-1:0]   issue_src_a_o,
  output logic [REG_W-1:0]   issue_src_b_o,
  output logic               busy_o,
  output logic               iter_done_o,
  output logic [N_EX:0]      stage_occ_o,
  output logic               wb_valid_o,
  output logic [REG_W-1:0]   wb_dst_o,
  output logic [LEN_W-1:0]   wb_idx_o
);
  localparam int unsigned N_OPND = 3;
  localparam int unsigned N_POST = N_EX;  // E2..E7 plus writeback

  logic             accept, e1_v, adv, last;
  logic [LEN_W-1:0] cnt;
  logic [OP_W-1:0]  op_q;
  logic [STR_W-1:0] stride_q;
  logic [REG_W-1:0] base_in [N_OPND];
  logic [REG_W-1:0] base_q  [N_OPND];
  logic [REG_W-1:0] idx_w   [N_OPND];
  logic [N_POST-1:0] post_occ;
  tag_t             e1_tag, tail;

  vis_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .len_i, .stall_i,
    .accept_o(accept), .e1_v_o(e1_v), .adv_o(adv), .last_o(last), .cnt_o(cnt)
  );

  assign base_in[0] = dst_i;
  assign base_in[1] = src_a_i;
  assign base_in[2] = src_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= '0;
      stride_q <= '0;
    end else if (accept) begin
      op_q     <= op_i;
      stride_q <= stride_i;
    end
  end

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     base_q[g] <= '0;
      else if (accept) base_q[g] <= base_in[g];
    end
    vis_idx_gen #(.REG_W(REG_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .STR_W(STR_W)) u_idx (
      .base_i(base_q[g]), .stride_i(stride_q), .cnt_i(cnt), .idx_o(idx_w[g])
    );
  end

  assign e1_tag = '{v: adv, dst: idx_w[0], idx: cnt};

  vis_tag_pipe #(.DEPTH(N_POST)) u_pipe (
    .clk_i, .rst_ni, .tag_i(e1_tag), .occ_o(post_occ), .tail_o(tail)
  );

  assign issue_valid_o = adv;
  assign issue_idx_o   = cnt;
  assign issue_op_o    = op_q;
  assign issue_dst_o   = idx_w[0];
  assign issue_src_a_o = idx_w[1];
  assign issue_src_b_o = idx_w[2];
  assign busy_o        = e1_v;
  assign iter_done_o   = adv & last;
  assign stage_occ_o   = {post_occ, e1_v};
  assign wb_valid_o    = tail.v;
  assign wb_dst_o      = tail.dst;
  assign wb_idx_o      = tail.idx;
endmodule

// File: rtl/vis_checker.sv
module vis_checker #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned LEN_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [REG_W-1:0] dst_i,
  input logic             stall_i,
  input logic             busy_o,
  input logic             issue_valid_o,
  input logic [LEN_W-1:0] issue_idx_o,
  input logic [REG_W-1:0] issue_dst_o,
  input logic             iter_done_o,
  input logic             e7_v,
  input logic             wb_valid_o
);
  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && issue_idx_o == '0 && issue_dst_o == $past(dst_i)));

  assert_next_elem_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !iter_done_o) |=> (busy_o && issue_idx_o == $past(issue_idx_o) + LEN_W'(1)));

  assert_bank_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !iter_done_o) |=> (issue_dst_o[REG_W-1:3] == $past(issue_dst_o[REG_W-1:3])));

  assert_done_issues_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_done_o |-> issue_valid_o);

  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stall_i) |=> (busy_o && $stable(issue_idx_o) && $stable(issue_dst_o)));

  assert_done_frees_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_done_o |=> !busy_o);

  assert_hold_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !iter_done_o) |=> busy_o);

  assert_wb_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(e7_v));
endmodule

bind vec_issue_seq vis_checker #(.REG_W(vis_pkg::REG_W), .LEN_W(vis_pkg::LEN_W)) u_vis_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .dst_i(dst_i), .stall_i(stall_i),
  .busy_o(busy_o), .issue_valid_o(issue_valid_o), .issue_idx_o(issue_idx_o),
  .issue_dst_o(issue_dst_o), .iter_done_o(iter_done_o),
  .e7_v(stage_occ_o[N_EX-1]), .wb_valid_o(wb_valid_o)
);

// File: tb/test_vec_issue_seq.sv
module test_vec_issue_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       start_i, stall_i;
  logic [3:0] op_i;
  logic [4:0] dst_i, src_a_i, src_b_i;
  logic [2:0] len_i;
  logic [1:0] stride_i;
  logic       issue_valid_o, busy_o, iter_done_o, wb_valid_o;
  logic [2:0] issue_idx_o, wb_idx_o;
  logic [3:0] issue_op_o;
  logic [4:0] issue_dst_o, issue_src_a_o, issue_src_b_o, wb_dst_o;
  logic [7:0] stage_occ_o;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model state
  int mv = 0, mc = 0, ml = 0, ms = 1, mop = 0, icnt = 0;
  int mbase [3];
  int pv [7];
  int pd [7];
  int pi [7];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vec_issue_seq i_vec_issue_seq (
    .clk_i, .rst_ni, .start_i, .op_i, .dst_i, .src_a_i, .src_b_i, .len_i, .stride_i,
    .stall_i, .issue_valid_o, .issue_idx_o, .issue_op_o, .issue_dst_o, .issue_src_a_o,
    .issue_src_b_o, .busy_o, .iter_done_o, .stage_occ_o, .wb_valid_o, .wb_dst_o, .wb_idx_o
  );

  function automatic int elem_idx(int base, int n, int step);
    return (base & 24) | ((base + n * step) % 8);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit st, input int ln, input int sr,
                     input int d, input int a, input int b, input bit stl);
    int exi, occ;
    start_i = st; len_i = 3'(ln); stride_i = 2'(sr); stall_i = stl;
    dst_i = 5'(d); src_a_i = 5'(a); src_b_i = 5'(b); op_i = 4'(ln + 3);
    #1;
    exi = (mv != 0 && !stl) ? 1 : 0;
    chk("R3 R7 issue_valid", int'(issue_valid_o), exi);
    chk("R8 R10 busy", int'(busy_o), mv);
    chk("R8 iter_done", int'(iter_done_o), (exi != 0 && mc == ml) ? 1 : 0);
    if (mv != 0) begin
      chk("R2 R3 issue_idx", int'(issue_idx_o), mc);
      chk("R2 R4 R5 dst", int'(issue_dst_o), elem_idx(mbase[0], mc, ms));
      chk("R2 R4 R5 src_a", int'(issue_src_a_o), elem_idx(mbase[1], mc, ms));
      chk("R2 R4 R5 src_b", int'(issue_src_b_o), elem_idx(mbase[2], mc, ms));
      chk("R2 op", int'(issue_op_o), mop);
    end
    occ = mv;
    for (int k = 0; k < 7; k++) occ |= pv[k] << (k + 1);
    chk("R9 stage_occ", int'(stage_occ_o), occ);
    chk("R9 wb_valid", int'(wb_valid_o), pv[6]);
    if (pv[6] != 0) begin
      chk("R9 wb_dst", int'(wb_dst_o), pd[6]);
      chk("R9 wb_idx", int'(wb_idx_o), pi[6]);
    end
    for (int k = 6; k > 0; k--) begin
      pv[k] = pv[k-1]; pd[k] = pd[k-1]; pi[k] = pi[k-1];
    end
    pv[0] = exi; pd[0] = elem_idx(mbase[0], mc, ms); pi[0] = mc;
    if (exi != 0) begin
      icnt++;
      if (mc == ml) begin
        chk("R3 R6 element count", icnt, ml + 1);
        icnt = 0;
      end
    end
    if (mv == 0 && st) begin
      mv = 1; mc = 0; ml = ln; ms = sr + 1; mop = ln + 3;
      mbase[0] = d; mbase[1] = a; mbase[2] = b;
    end else if (exi != 0) begin
      if (mc == ml) mv = 0;
      else mc++;
    end
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int k = 0; k < 7; k++) begin pv[k] = 0; pd[k] = 0; pi[k] = 0; end
    for (int k = 0; k < 3; k++) mbase[k] = 0;
    rst_ni = 0; start_i = 0; stall_i = 0; op_i = 0;
    dst_i = 0; src_a_i = 0; src_b_i = 0; len_i = 0; stride_i = 0;
    repeat (2) @(negedge clk_i);
    chk("R1 busy in reset", int'(busy_o), 0);
    chk("R1 occupancy in reset", int'(stage_occ_o), 0);
    chk("R1 issue_valid in reset", int'(issue_valid_o), 0);
    chk("R1 wb_valid in reset", int'(wb_valid_o), 0);
    rst_ni = 1;
    idle(1);
    // R3 R4 R5: four elements, step one, offsets 6,7,0,1 in bank 1
    cyc(1, 3, 0, 14, 24, 4, 0);
    idle(5);
    // R4: step four, two elements
    cyc(1, 1, 3, 9, 2, 31, 0);
    idle(3);
    // R6: scalar
    cyc(1, 0, 0, 5, 6, 7, 0);
    idle(9);
    // R7: stalls in mid-sequence, and at the first element
    cyc(1, 3, 1, 3, 16, 27, 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    idle(4);
    // R8: start while busy is ignored; R10: next start as soon as E1 frees
    cyc(1, 7, 1, 8, 0, 15, 0);
    cyc(1, 2, 3, 1, 1, 1, 0);
    cyc(1, 2, 3, 1, 1, 1, 0);
    for (int i = 0; i < 7; i++) cyc(1, 2, 2, 20, 21, 22, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    // R10: back-to-back scalars with a full tail
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, i, i + 8, i + 16, 0);
    idle(12);
    // R3: stall while idle has no effect on the next accept
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(1, 4, 2, 30, 12, 1, 1);
    idle(14);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule